// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Latching Register

The block collects a serial bit stream into a shift stage on one clock and transfers the whole stage into a holding register on a second, independent clock. Because the two clocks are separate, a new word can be shifted in while the previous word stays on the parallel outputs. The transfer then updates every output bit in the same storage edge.

An active-low asynchronous clear empties the shift stage only and leaves the holding register alone. An active-low output enable either drives the held word or releases the parallel bus to high impedance. A separate valid flag gives the same information to synthesized logic that cannot use a floating bus. The serial cascade output carries the last shift bit regardless of the output enable.

A chain parameter stacks several byte-wide slices behind one serial input and one storage clock. The whole word is shifted in most significant bit first and becomes visible after a single storage pulse.

Top module: `shift_latch_chain`

## Requirements
- R1: On each rising edge of `shift_clk_i` with `rst_ni` high, shift bit 0 takes `ser_i` and every shift bit k>0 takes the previous value of bit k-1, across all slices of the chain.
- R2: The holding register changes only on rising edges of `store_clk_i`; any number of shift edges without a storage edge leave `par_o` unchanged.
- R3: On a rising edge of `store_clk_i` the holding register takes all BYTE_W*CHAIN shift bits in parallel.
- R4: While `rst_ni` is low the shift stage is zero at once, without a clock edge, and shift edges have no effect; `casc_o` reads 0.
- R5: `rst_ni` has no effect on the holding register: `par_o` keeps its word through a clear.
- R6: With `oe_ni` high, `par_o` is high impedance on every bit and `par_valid_o` is 0; with `oe_ni` low, `par_o` drives the holding register and `par_valid_o` is 1.
- R7: `casc_o` always equals the last shift bit (bit BYTE_W*CHAIN-1), for either level of `oe_ni`.
- R8: When both clocks rise on the same edge, the holding register captures the shift contents from before that edge's shift.
- R9: A word of BYTE_W*CHAIN bits shifted in most significant bit first, followed by one storage edge, appears unchanged on `par_o`; `par_o[BYTE_W*i+j]` is bit j of slice i, and slice i feeds slice i+1 from its bit BYTE_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift clock, rising edge |
| store_clk_i | input | 1 | Storage clock, rising edge |
| rst_ni | input | 1 | Asynchronous clear of the shift stage, active low |
| ser_i | input | 1 | Serial data input |
| oe_ni | input | 1 | Parallel output enable, active low |
| par_o | output | BYTE_W*CHAIN | Parallel outputs, high impedance when disabled |
| par_valid_o | output | 1 | High when `par_o` is driven |
| casc_o | output | 1 | Serial cascade output, last shift bit |

## Verification
The shift and transfer assertions take for granted that `ser_i` is steady around each shift edge, that the clear is applied before the first clock edge so every shift bit is defined, and that the clear is never released at the same instant as a shift edge. The bench keeps inside these bounds by changing data, clear and enable only while both clocks are low, half a period away from any rising edge. The holding register starts unknown, so no output check is made before the first storage edge.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int unsigned SLC_BYTE_W = 8;
  localparam int unsigned SLC_CHAIN  = 2;
endpackage

// File: rtl/slc_shift_stage.sv
module slc_shift_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o,
  output logic             last_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[WIDTH-2:0], ser_i};
  end

  assign q_o    = q;
  assign last_o = q[WIDTH-1];

  assert_shift_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1 |=> (q_o[0] == $past(ser_i)) && (q_o[WIDTH-1:1] == $past(q_o[WIDTH-2:0])));
endmodule

// File: rtl/slc_hold_reg.sv
module slc_hold_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // no reset: contents are undefined until the first storage edge
  always_ff @(posedge clk_i) q_o <= d_i;
endmodule

// File: rtl/slc_out_drv.sv
module slc_out_drv #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             valid_o
);
  assign bus_o   = oe_ni ? {WIDTH{1'bz}} : d_i;
  assign valid_o = ~oe_ni;
endmodule

// File: rtl/shift_latch_chain.sv
module shift_latch_chain
  import slc_pkg::*;
#(
  parameter  int unsigned BYTE_W = SLC_BYTE_W,
  parameter  int unsigned CHAIN  = SLC_CHAIN,
  localparam int unsigned WordW  = BYTE_W * CHAIN
) (
  input  logic             shift_clk_i,
  input  logic             store_clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             oe_ni,
  output logic [WordW-1:0] par_o,
  output logic             par_valid_o,
  output logic             casc_o
);
  logic [CHAIN:0]     link;
  logic [WordW-1:0]   sr_all;
  logic [WordW-1:0]   hold_all;

  assign link[0] = ser_i;

  for (genvar gi = 0; gi < CHAIN; gi++) begin : g_slice
    slc_shift_stage #(.WIDTH(BYTE_W)) i_sr (
      .clk_i  (shift_clk_i),
      .rst_ni (rst_ni),
      .ser_i  (link[gi]),
      .q_o    (sr_all[gi*BYTE_W +: BYTE_W]),
      .last_o (link[gi+1])
    );
    slc_hold_reg #(.WIDTH(BYTE_W)) i_hold (
      .clk_i (store_clk_i),
      .d_i   (sr_all[gi*BYTE_W +: BYTE_W]),
      .q_o   (hold_all[gi*BYTE_W +: BYTE_W])
    );
  end

  slc_out_drv #(.WIDTH(WordW)) i_drv (
    .oe_ni   (oe_ni),
    .d_i     (hold_all),
    .bus_o   (par_o),
    .valid_o (par_valid_o)
  );

  assign casc_o = link[CHAIN];

  // slice boundaries pass the top bit of one slice into the next
  for (genvar gj = 1; gj < CHAIN; gj++) begin : g_link_chk
    assert_slice_link_R9: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
      1 |=> sr_all[gj*BYTE_W] == $past(sr_all[gj*BYTE_W-1]));
  end

  assert_capture_R3: assert property (@(posedge store_clk_i) disable iff (!rst_ni)
    1 |=> hold_all == $past(sr_all));

  assert_cascade_R7: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    1 |=> casc_o == $past(sr_all[WordW-2]));
endmodule

// File: tb/test_shift_latch_chain.sv
module test_shift_latch_chain;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CHAIN      = 2;
  localparam int unsigned W          = BYTE_W * CHAIN;
  localparam time         CLK_PERIOD = 10ns;
  localparam time         HALF       = CLK_PERIOD / 2;

  logic         shift_clk, store_clk, rst_n, ser, oe_n;
  logic [W-1:0] par;
  logic         par_valid, casc;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] exp_sr;
  logic [W-1:0] exp_hold;

  shift_latch_chain #(.BYTE_W(BYTE_W), .CHAIN(CHAIN)) i_shift_latch_chain (
    .shift_clk_i (shift_clk),
    .store_clk_i (store_clk),
    .rst_ni      (rst_n),
    .ser_i       (ser),
    .oe_ni       (oe_n),
    .par_o       (par),
    .par_valid_o (par_valid),
    .casc_o      (casc)
  );

  function automatic logic [W-1:0] model_shift(logic [W-1:0] s, logic b, logic clr_n);
    if (!clr_n) return '0;
    return {s[W-2:0], b};
  endfunction

  task automatic check_bus(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // released bus: floating value, or zero where a simulator folds floating nets
  task automatic check_hiz(string tag);
    checks++;
    if (!((par === {W{1'bz}}) || (par === '0 && exp_hold != '0)) || par_valid !== 1'b0) begin
      failures++;
      $display("FAIL %s actual=%h valid=%b expected=z valid=0", tag, par, par_valid);
    end
  endtask

  task automatic shift_bit(logic b);
    ser = b;
    #HALF shift_clk = 1'b1;
    exp_sr = model_shift(exp_sr, b, rst_n);
    #HALF shift_clk = 1'b0;
  endtask

  task automatic store_pulse();
    #HALF store_clk = 1'b1;
    exp_hold = exp_sr;
    #HALF store_clk = 1'b0;
  endtask

  task automatic both_pulse(logic b);
    ser = b;
    #HALF begin shift_clk = 1'b1; store_clk = 1'b1; end
    exp_hold = exp_sr;
    exp_sr = model_shift(exp_sr, b, rst_n);
    #HALF begin shift_clk = 1'b0; store_clk = 1'b0; end
  endtask

  task automatic shift_word(logic [W-1:0] w);
    for (int k = W - 1; k >= 0; k--) begin
      shift_bit(w[k]);
      check_bit("R7 cascade tracks last bit", casc, exp_sr[W-1]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    logic [W-1:0] keep;
    int unsigned  seed_v;
    seed_v = $urandom(32'h0C0FFEE5);
    shift_clk = 0; store_clk = 0; rst_n = 0; ser = 0; oe_n = 0;
    exp_sr = '0; exp_hold = '0;
    #CLK_PERIOD;
    check_bit("R4 reset cascade", casc, 1'b0);
    store_pulse();
    #1 check_bus("R3 reset contents transferred", par, '0);
    check_bit("R6 valid when enabled", par_valid, 1'b1);
    rst_n = 1;
    #CLK_PERIOD;

    // directed MSB-first word across slices
    shift_word(16'hA5_3C);
    store_pulse();
    #1 check_bus("R9 directed word", par, 16'hA5_3C);

    // random words, random enable
    for (int n = 0; n < 40; n++) begin
      w = W'($urandom);
      oe_n = $urandom_range(0, 1);
      shift_word(w);
      check_bus("R1 shift model", exp_sr, w);
      keep = exp_hold;
      if (!oe_n) check_bus("R2 no store keeps outputs", par, keep);
      store_pulse();
      #1;
      if (oe_n) begin
        check_hiz("R6 disabled outputs");
        oe_n = 0;
        #1;
      end
      check_bus("R9 random word", par, w);
      // partial shift, no store
      for (int k = 0; k < int'($urandom_range(1, W - 1)); k++) shift_bit(1'($urandom));
      check_bus("R2 partial shift outputs unchanged", par, w);
    end

    // async clear, hold untouched
    shift_word('1);
    store_pulse();
    shift_word(16'h0F0F);
    #(HALF / 2) rst_n = 0;
    exp_sr = '0;
    #1 check_bit("R4 immediate clear", casc, 1'b0);
    check_bus("R5 clear leaves outputs", par, '1);
    shift_bit(1'b1);
    shift_bit(1'b1);
    check_bit("R4 clear overrides shift", casc, 1'b0);
    store_pulse();
    #1 check_bus("R4 shift stage empty", par, '0);
    #HALF rst_n = 1;
    #CLK_PERIOD;

    // tied clocks
    shift_word(16'h8001);
    store_pulse();
    both_pulse(1'b1);
    #1 check_bus("R8 tied clocks capture pre-shift", par, 16'h8001);
    store_pulse();
    #1 check_bus("R8 later store sees shifted", par, 16'h0003);

    // cascade unaffected by output enable
    oe_n = 1;
    shift_word(16'h8000);
    #1 check_bit("R7 cascade with outputs disabled", casc, 1'b1);
    check_hiz("R6 outputs released");
    oe_n = 0;
    #1 check_bus("R6 outputs driven again", par, 16'h0003);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule